// File: doc/BRIEF.md
# Two-Stage Register Add Pipeline with Result Bypass

This block executes a stream of register-to-register add operations in two overlapped steps. In the first step, the incoming operation reads its two source registers and forms their sum. That sum, together with the operation's destination and source indices, is captured in a single holding slot between the stages. In the second step, the held sum is written into the held destination. Both steps act on the same clock edge. The operation leaving the slot writes back while the next operation enters it.

Because the write of the held result and the read for the next operation happen in the same cycle, a dependent operation would otherwise see a stale register value. A bypass on each operand closes that gap. When the slot is occupied and its destination equals a source index of the incoming operation, the held sum replaces the register-file value for that operand.

A side port reads any register combinationally. The same port can also write a register, but only while the pipeline is completely idle, so the register file can be preloaded and inspected. The holding slot is a two-state machine:

- SLOT_IDLE: the slot holds nothing.
- SLOT_BUSY: the slot holds one operation.

Its transitions are:

- ISSUE: SLOT_IDLE to SLOT_BUSY on a valid operation.
- STREAM: SLOT_BUSY to SLOT_BUSY on a valid operation.
- DRAIN: SLOT_BUSY to SLOT_IDLE when no operation is offered.
- REST: SLOT_IDLE to SLOT_IDLE when no operation is offered.

Top module: `addpipe_top`

## Requirements
- R1: After reset every register reads zero and the slot is in SLOT_IDLE.
- R2: An operation offered with `op_valid` high at clock edge k writes `rf[src_a] + rf[src_b]` (modulo 2^DW, as seen by a sequential one-at-a-time model) into `rf[dst]` at edge k+1.
- R3: Any edge with `op_valid` high leaves the slot in SLOT_BUSY, and any edge with it low leaves the slot in SLOT_IDLE. A held operation writes back on the next edge whether or not a new operation arrives.
- R4: When the slot is busy and its destination equals the incoming `src_a`, the held sum is used as the first operand.
- R5: When the slot is busy and its destination equals the incoming `src_b`, the held sum is used as the second operand.
- R6: When the held destination equals both incoming sources, including an operation whose destination is also its own source, both operands are bypassed.
- R7: When the held destination matches neither source, both operands come from the register file.
- R8: An idle slot performs no writeback and enables no bypass, even when its stale destination field matches a source.
- R9: `peek_addr` selects the register shown on `peek_data` combinationally. A write with `poke_en` high at an edge where `op_valid` is low and the slot is SLOT_IDLE stores `poke_data` at `peek_addr`.
- R10: A side-port write is ignored when `op_valid` is high or the slot is SLOT_BUSY at that edge.
- R11: While the slot is busy, the held sum equals the sum of the current register-file values of the held operation's two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An add operation is offered this cycle |
| op_dst | input | AW | Destination register index |
| op_src_a | input | AW | First source register index |
| op_src_b | input | AW | Second source register index |
| poke_en | input | 1 | Side-port write request (honoured only when idle) |
| peek_addr | input | AW | Side-port register index for read and write |
| poke_data | input | DW | Side-port write value |
| peek_data | output | DW | Value of the register selected by `peek_addr` |

## Verification
The bench targets the following dependency cases:

- Back-to-back dependent pairs on the first source, the second source and both sources, plus self-accumulating chains.
- Independent operations, used as the no-hazard contrast.

A missing or mis-steered bypass would store a sum built from the value that was about to be overwritten. This shows up as a wrong register value one edge after the dependent operation is captured.

Two further cases are checked:

- An idle slot whose stale destination matches a source. If the bypass ignored the slot state, it would reuse the old sum instead of a freshly poked register.
- Side-port writes made while an operation is offered or still draining. A design that accepted them would corrupt a register the final comparison against the sequential model then exposes.

// File: rtl/addpipe_pkg.sv
package addpipe_pkg;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;

    localparam int unsigned OPERANDS = 2;

endpackage

// File: rtl/apl_regfile.sv
module apl_regfile #(
    parameter int unsigned AW  = 5,
    parameter int unsigned DW  = 32,
    parameter int unsigned NRD = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0][DW-1:0]  rd_data
);
    localparam int unsigned NREGS = 1 << AW;

    logic [DW-1:0] mem [NREGS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end

endmodule

// File: rtl/apl_bypass.sv
module apl_bypass #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input  logic          fwd_en,
    input  logic [AW-1:0] fwd_dst,
    input  logic [DW-1:0] fwd_val,
    input  logic [AW-1:0] src,
    input  logic [DW-1:0] rf_val,
    output logic [DW-1:0] operand
);
    logic hit;

    always_comb begin
        hit     = fwd_en && (fwd_dst == src);
        operand = hit ? fwd_val : rf_val;
    end

endmodule

// File: rtl/apl_slot.sv
module apl_slot
    import addpipe_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [AW-1:0] new_dst,
    input  logic [AW-1:0] new_src_a,
    input  logic [AW-1:0] new_src_b,
    input  logic [DW-1:0] new_sum,
    output logic          busy,
    output logic [AW-1:0] held_dst,
    output logic [AW-1:0] held_src_a,
    output logic [AW-1:0] held_src_b,
    output logic [DW-1:0] held_sum
);
    slot_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_IDLE: state_d = take ? SLOT_BUSY : SLOT_IDLE;
            SLOT_BUSY: state_d = take ? SLOT_BUSY : SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SLOT_IDLE;
            held_dst   <= '0;
            held_src_a <= '0;
            held_src_b <= '0;
            held_sum   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                held_dst   <= new_dst;
                held_src_a <= new_src_a;
                held_src_b <= new_src_b;
                held_sum   <= new_sum;
            end
        end
    end

    always_comb begin
        busy = (state_q == SLOT_BUSY);
    end

    // R1
    idle_after_reset_chk: assert property (@(posedge clk)
        !rst_n |=> state_q == SLOT_IDLE);

endmodule

// File: rtl/addpipe_top.sv
module addpipe_top
    import addpipe_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [AW-1:0] op_dst,
    input  logic [AW-1:0] op_src_a,
    input  logic [AW-1:0] op_src_b,
    input  logic          poke_en,
    input  logic [AW-1:0] peek_addr,
    input  logic [DW-1:0] poke_data,
    output logic [DW-1:0] peek_data
);
    localparam int unsigned NRD     = 5;
    localparam int unsigned RD_A    = 0;
    localparam int unsigned RD_B    = 1;
    localparam int unsigned RD_PEEK = 2;
    localparam int unsigned RD_HA   = 3;
    localparam int unsigned RD_HB   = 4;

    logic                          slot_busy;
    logic [AW-1:0]                 h_dst, h_src_a, h_src_b;
    logic [DW-1:0]                 h_sum;
    logic [NRD-1:0][AW-1:0]        rd_addr;
    logic [NRD-1:0][DW-1:0]        rd_data;
    logic [OPERANDS-1:0][AW-1:0]   src_idx;
    logic [OPERANDS-1:0][DW-1:0]   opnd;
    logic [DW-1:0]                 fresh_sum;
    logic                          poke_ok;
    logic                          wr_en;
    logic [AW-1:0]                 wr_addr;
    logic [DW-1:0]                 wr_data;
    logic [DW-1:0]                 held_src_sum;

    always_comb begin
        rd_addr[RD_A]    = op_src_a;
        rd_addr[RD_B]    = op_src_b;
        rd_addr[RD_PEEK] = peek_addr;
        rd_addr[RD_HA]   = h_src_a;
        rd_addr[RD_HB]   = h_src_b;
        src_idx[0]       = op_src_a;
        src_idx[1]       = op_src_b;
    end

    apl_regfile #(.AW(AW), .DW(DW), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < OPERANDS; g++) begin : g_opnd
        apl_bypass #(.AW(AW), .DW(DW)) u_byp (
            .fwd_en  (slot_busy),
            .fwd_dst (h_dst),
            .fwd_val (h_sum),
            .src     (src_idx[g]),
            .rf_val  (rd_data[g]),
            .operand (opnd[g])
        );
    end

    always_comb begin
        fresh_sum = opnd[0] + opnd[1];
    end

    apl_slot #(.AW(AW), .DW(DW)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (op_valid),
        .new_dst    (op_dst),
        .new_src_a  (op_src_a),
        .new_src_b  (op_src_b),
        .new_sum    (fresh_sum),
        .busy       (slot_busy),
        .held_dst   (h_dst),
        .held_src_a (h_src_a),
        .held_src_b (h_src_b),
        .held_sum   (h_sum)
    );

    always_comb begin
        poke_ok   = poke_en && !op_valid && !slot_busy;
        wr_en     = slot_busy || poke_ok;
        wr_addr   = slot_busy ? h_dst : peek_addr;
        wr_data   = slot_busy ? h_sum : poke_data;
        peek_data = rd_data[RD_PEEK];
    end

    assign held_src_sum = rd_data[RD_HA] + rd_data[RD_HB];

    // R11
    held_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_busy |-> h_sum == held_src_sum);

    // R3
    take_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> slot_busy);

    // R3
    drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !slot_busy);

    // R4
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && slot_busy && h_dst == op_src_a) |-> opnd[0] == h_sum);

    // R5
    fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && slot_busy && h_dst == op_src_b) |-> opnd[1] == h_sum);

    // R7
    rf_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(slot_busy && h_dst == op_src_a)) |-> opnd[0] == rd_data[RD_A]);

endmodule

// File: tb/sim_addpipe_top.sv
module sim_addpipe_top;
    localparam int unsigned AW     = 5;
    localparam int unsigned DW     = 32;
    localparam int unsigned NREGS  = 1 << AW;
    localparam time         CLK_PER = 10;

    typedef struct {
        logic [AW-1:0] dst;
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [AW-1:0] op_dst = '0;
    logic [AW-1:0] op_src_a = '0;
    logic [AW-1:0] op_src_b = '0;
    logic          poke_en = 1'b0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] poke_data = '0;
    logic [DW-1:0] peek_data;

    logic [DW-1:0] model_rf [NREGS];
    exp_t          sb_q [$];
    exp_t          mon_item;
    bit            mon_have = 1'b0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    addpipe_top #(.AW(AW), .DW(DW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_dst    (op_dst),
        .op_src_a  (op_src_a),
        .op_src_b  (op_src_b),
        .poke_en   (poke_en),
        .peek_addr (peek_addr),
        .poke_data (poke_data),
        .peek_data (peek_data)
    );

    always #(CLK_PER / 2) clk = ~clk;

    task automatic check(input bit ok, input string req,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: present one operation, update the sequential model, push expectation.
    task automatic issue(input logic [AW-1:0] d, input logic [AW-1:0] a,
                         input logic [AW-1:0] b, input string tag);
        exp_t e;
        op_valid = 1'b1;
        op_dst   = d;
        op_src_a = a;
        op_src_b = b;
        e.dst = d;
        e.val = model_rf[a] + model_rf[b];
        e.tag = tag;
        model_rf[d] = e.val;
        sb_q.push_back(e);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic bubble(input int n);
        op_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic poke(input logic [AW-1:0] a, input logic [DW-1:0] v);
        poke_en   = 1'b1;
        peek_addr = a;
        poke_data = v;
        model_rf[a] = v;
        @(negedge clk);
        poke_en = 1'b0;
        #1;
        check(peek_data == v, "R9", peek_data, v);
    endtask

    task automatic peek_check(input logic [AW-1:0] a, input string req);
        peek_addr = a;
        #1;
        check(peek_data == model_rf[a], req, peek_data, model_rf[a]);
    endtask

    // Monitor: the operation captured at one edge commits at the next.
    always @(posedge clk) begin
        #2;
        if (mon_have) begin
            peek_addr = mon_item.dst;
            #1;
            check(peek_data == mon_item.val, mon_item.tag, peek_data, mon_item.val);
            mon_have = 1'b0;
        end
        if (rst_n && op_valid && sb_q.size() > 0) begin
            mon_item = sb_q.pop_front();
            mon_have = 1'b1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREGS; i++) model_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all registers zero after reset
        for (int i = 0; i < NREGS; i++) peek_check(AW'(i), "R1");

        // R9: seed registers through the idle side port
        for (int i = 1; i < NREGS; i++) poke(AW'(i), 32'h100 * i + 32'h3);

        // R7: independent operation
        issue(5'd20, 5'd1, 5'd2, "R7");
        issue(5'd21, 5'd3, 5'd4, "R7");
        // R4: dependency on the first source
        issue(5'd3, 5'd1, 5'd2, "R4");
        issue(5'd4, 5'd3, 5'd5, "R4");
        // R5: dependency on the second source
        issue(5'd8, 5'd1, 5'd1, "R5");
        issue(5'd9, 5'd2, 5'd8, "R5");
        // R6: dependency on both sources, then a self-accumulating chain
        issue(5'd10, 5'd1, 5'd2, "R6");
        issue(5'd11, 5'd10, 5'd10, "R6");
        issue(5'd12, 5'd12, 5'd12, "R6");
        issue(5'd12, 5'd12, 5'd1, "R6");
        issue(5'd12, 5'd12, 5'd12, "R6");
        // R3: writeback happens on the edge with no new operation
        issue(5'd13, 5'd6, 5'd7, "R3");
        bubble(2);
        peek_check(5'd13, "R3");

        // R8: idle slot with a stale matching destination must not bypass
        poke(5'd13, 32'h5555_0000);
        issue(5'd14, 5'd13, 5'd1, "R8");
        issue(5'd15, 5'd2, 5'd13, "R8");
        bubble(2);

        // R10: side write while an operation is offered is ignored
        poke_en   = 1'b1;
        peek_addr = 5'd7;
        poke_data = 32'hDEAD_BEEF;
        issue(5'd16, 5'd1, 5'd2, "R2");
        // R10: side write while the slot is draining is ignored
        peek_addr = 5'd6;
        poke_data = 32'hBAD0_0BAD;
        @(negedge clk);
        poke_en = 1'b0;
        bubble(2);
        peek_check(5'd7, "R10");
        peek_check(5'd6, "R10");

        // R2: random streams rich in dependent pairs
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] d, a, b;
            d = AW'($urandom);
            a = AW'($urandom);
            b = AW'($urandom);
            if ($urandom % 2 == 0) a = op_dst;
            if ($urandom % 3 == 0) b = op_dst;
            if ($urandom % 8 == 0) bubble(1 + $urandom % 2);
            issue(d, a, b, "R2");
        end
        bubble(3);

        // R2: final register file equals the sequential model
        for (int i = 0; i < NREGS; i++) peek_check(AW'(i), "R2");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule